// File: doc/BRIEF.md
# Address Translation Sequencer

This block steers a single address-translation request from start to finish. A request carries a 32-bit effective address, an access kind (read, write or instruction fetch), a data-operation class, and three machine-state bits: instruction-translate enable, data-translate enable and problem (user) state. The sequencer works through a fixed order of steps:

1. Real-mode bypass.
2. Block translation, run by an external engine.
3. Segment word lookup.
4. Direct-store handling.
5. Segment no-execute check.
6. Hashed page-table search, run by a second external engine.

It finishes with one `done` pulse. That pulse carries either a physical page number with rights, or an exception class, a 32-bit syndrome word and the faulting effective address.

The two engines are driven by level requests. Each request stays high until the engine returns a one-cycle response. Segment words live outside the block. The sequencer presents a 4-bit segment index and reads the matching word combinationally. A new request is taken only while the block is idle, which is after the previous `done`.

The states are:

- `S_IDLE`: waits for a request.
- `S_BLOCK`: block engine busy.
- `S_SEGMENT`: segment word decided.
- `S_TABLE`: page-table engine busy.
- `S_REPORT`: result presented for one cycle.

The transitions are:

- idle→report on a real-mode request.
- idle→block on a translated request.
- block→report on a block hit.
- block→segment on a block miss.
- segment→report on a direct-store segment or a no-execute fetch.
- segment→table otherwise.
- table→report on the page-table response.
- report→idle always.

Top module: `xlat_seq`

## Requirements
- R1: When a fetch (kind 2) arrives with instruction translation disabled, or a read/write (kind 0/1; kind 3 behaves as read) arrives with data translation disabled, the result is success with page number = effective address bits 31..12 and rights 3'b111 (bit 2 read, bit 1 write, bit 0 execute), and neither engine is requested.
- R2: Otherwise the block engine is consulted first. On a hit with access allowed, the result is its page number and rights, and no page-table request is made. On a miss, processing continues to the segment word.
- R3: A block hit whose access is not allowed gives a protection fault: fetch → class 1 (instruction storage) code 0x08000000; data → class 2 (data storage) code 0x08000000.
- R4: The segment word is selected by effective-address bits 31..28 on `seg_idx`. Segment bit 31 marks direct store, bit 30 is the supervisor key, bit 29 is the user key, bit 28 is no-execute, bits 23..0 are the VSID, and for direct store bits 28..20 are the bus-unit id and bits 3..0 the high address nibble. The key passed to the page-table engine is bit 29 in problem state, bit 30 otherwise.
- R5: A direct-store segment with bus-unit id 0x07F succeeds for any access with page = {segment bits 3..0, EA bits 27..12} and rights 3'b111.
- R6: Other direct-store segments behave by access:
  - A fetch gives class 1 code 0x10000000.
  - A data op of 1 (floating point) gives class 3 (alignment) with code 0.
  - Op 2 (reservation) gives class 2 code 0x04000000.
  - Op 3 (external control) gives class 2 code 0x04100000.
- R7: A direct-store integer access (op 0) selects the key by problem state as in R4. A read is granted when that key is 0 and a write when it is 1, with page = EA bits 31..12 and rights 3'b110. Otherwise the result is a protection fault.
- R8: A fetch from a non-direct-store segment with no-execute set gives class 1 code 0x10000000 without any page-table request. A data access to such a segment proceeds, with `pt_nx` high.
- R9: Page-table outcomes are as follows:
  - Not found: fetch gives class 1 code 0x40000000; data gives class 2 code 0x40000000.
  - Found but not allowed: protection fault as in R3.
  - Found and allowed: success with the engine's page and rights, class 0 and code 0.
- R10: Every class-2 code produced by a write has bit 25 (0x02000000) added, for example 0x42000000, 0x0A000000, 0x06000000 and 0x06100000.
- R11: Class 2 and class 3 results report the request's effective address on `fault_ea`. Class 1 results and successes report 0.
- R12: Each accepted request yields exactly one single-cycle `done`. `busy` is high from acceptance through `done`. `req_valid` while busy is ignored. After reset, `busy`, `done` and both engine requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_op | input | 2 | 0 integer, 1 floating point, 2 reservation, 3 external control |
| itx_en | input | 1 | Instruction translation enable |
| dtx_en | input | 1 | Data translation enable |
| prob_state | input | 1 | Problem (user) state |
| busy | output | 1 | Request in flight |
| blk_req | output | 1 | Block engine request, held until response |
| blk_ea | output | 32 | Address for block engine |
| blk_kind | output | 2 | Access kind for block engine |
| blk_prob | output | 1 | Problem state for block engine |
| blk_rsp_valid | input | 1 | Block engine response strobe |
| blk_hit | input | 1 | Block entry matched |
| blk_allow | input | 1 | Block access permitted |
| blk_pn | input | PN_W | Block physical page number |
| blk_rights | input | 3 | Block rights {R,W,X} |
| seg_idx | output | 4 | Segment word index |
| seg_word | input | 32 | Selected segment word |
| pt_req | output | 1 | Page-table engine request, held until response |
| pt_ea | output | 32 | Address for page-table search |
| pt_vsid | output | VSID_W | VSID from segment word |
| pt_kind | output | 2 | Access kind for page-table engine |
| pt_key | output | 1 | Selected protection key |
| pt_nx | output | 1 | Segment no-execute flag |
| pt_rsp_valid | input | 1 | Page-table response strobe |
| pt_found | input | 1 | Entry found |
| pt_allow | input | 1 | Access permitted |
| pt_pn | input | PN_W | Physical page number |
| pt_rights | input | 3 | Rights {R,W,X} |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Translation succeeded |
| done_pn | output | PN_W | Physical page number on success |
| done_rights | output | 3 | Rights on success |
| exc_class | output | 2 | 0 none, 1 instruction storage, 2 data storage, 3 alignment |
| exc_code | output | 32 | Syndrome word |
| fault_ea | output | 32 | Faulting effective address for data faults |

## Verification
The hardest region to reach is deep in the chain: a direct-store segment behind a block miss. There the outcome depends jointly on access kind, data operation, problem state and the two key bits. The bench reaches it by programming a sixteen-entry segment table and forcing the block engine to miss, then sweeping kind, operation and key. A request pulsed while the engines are stalled by programmed response delays checks that the in-flight result is not disturbed.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        OP_INT   = 2'd0,
        OP_FLOAT = 2'd1,
        OP_RSV   = 2'd2,
        OP_EXT   = 2'd3
    } data_op_t;

    typedef enum logic [1:0] {
        EXC_NONE   = 2'd0,
        EXC_ISTORE = 2'd1,
        EXC_DSTORE = 2'd2,
        EXC_ALIGN  = 2'd3
    } exc_class_t;

    typedef enum logic [2:0] {
        FLT_NONE,
        FLT_MISS,
        FLT_PROT,
        FLT_NOEXEC,
        FLT_DS_FETCH,
        FLT_DS_RSV,
        FLT_DS_EXT,
        FLT_DS_FP
    } fault_t;

    localparam int SEG_DSTORE = 31;
    localparam int SEG_KEY_SV = 30;
    localparam int SEG_KEY_PR = 29;
    localparam int SEG_NOEXEC = 28;

    localparam logic [31:0] SYN_MISS     = 32'h4000_0000;
    localparam logic [31:0] SYN_PROT     = 32'h0800_0000;
    localparam logic [31:0] SYN_NOEXEC   = 32'h1000_0000;
    localparam logic [31:0] SYN_DS_RSV   = 32'h0400_0000;
    localparam logic [31:0] SYN_DS_EXT   = 32'h0410_0000;
    localparam logic [31:0] SYN_STORE    = 32'h0200_0000;

    localparam logic [2:0] RIGHTS_ALL = 3'b111;
    localparam logic [2:0] RIGHTS_RW  = 3'b110;

endpackage

// File: rtl/xlat_syndrome.sv
module xlat_syndrome
    import xlat_pkg::*;
(
    input  fault_t      flt,
    input  logic        is_fetch,
    input  logic        is_store,
    input  logic [31:0] ea,
    output logic [1:0]  cls,
    output logic [31:0] code,
    output logic [31:0] faddr
);

    logic [31:0] st_bit;

    always_comb begin
        st_bit = is_store ? SYN_STORE : 32'h0;
        cls    = EXC_NONE;
        code   = 32'h0;
        faddr  = 32'h0;
        if (flt != FLT_NONE) begin
            if (is_fetch) begin
                cls = EXC_ISTORE;
                case (flt)
                    FLT_MISS: code = SYN_MISS;
                    FLT_PROT: code = SYN_PROT;
                    default:  code = SYN_NOEXEC;
                endcase
            end else begin
                faddr = ea;
                case (flt)
                    FLT_MISS: begin
                        cls  = EXC_DSTORE;
                        code = SYN_MISS | st_bit;
                    end
                    FLT_DS_RSV: begin
                        cls  = EXC_DSTORE;
                        code = SYN_DS_RSV | st_bit;
                    end
                    FLT_DS_EXT: begin
                        cls  = EXC_DSTORE;
                        code = SYN_DS_EXT | st_bit;
                    end
                    FLT_DS_FP: begin
                        cls  = EXC_ALIGN;
                        code = 32'h0;
                    end
                    default: begin
                        cls  = EXC_DSTORE;
                        code = SYN_PROT | st_bit;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/xlat_dstore.sv
module xlat_dstore
    import xlat_pkg::*;
#(
    parameter int          PAGE_W = 12,
    parameter int          BUID_W = 9,
    parameter logic [BUID_W-1:0] BUS_ID = 9'h07F,
    localparam int         PN_W   = 32 - PAGE_W
) (
    input  logic [31:0]     seg,
    input  logic [31:0]     ea,
    input  logic            is_fetch,
    input  logic            is_store,
    input  logic            prob,
    input  logic [1:0]      op,
    output fault_t          flt,
    output logic [PN_W-1:0] pn,
    output logic [2:0]      rights
);

    logic        forced;
    logic        key;
    logic        grant;
    logic [31:0] forced_pa;
    logic        ds_unused;

    assign forced    = (seg[SEG_NOEXEC -: BUID_W] == BUS_ID);
    assign key       = prob ? seg[SEG_KEY_PR] : seg[SEG_KEY_SV];
    assign grant     = is_store ? key : !key;
    assign forced_pa = {seg[3:0], ea[27:0]};
    assign ds_unused = ^{forced_pa[PAGE_W-1:0], ea[PAGE_W-1:0], seg[19:4], seg[31:29]};

    always_comb begin
        flt    = FLT_NONE;
        pn     = '0;
        rights = 3'b000;
        if (forced) begin
            pn     = forced_pa[31:PAGE_W];
            rights = RIGHTS_ALL;
        end else if (is_fetch) begin
            flt = FLT_DS_FETCH;
        end else begin
            unique case (op)
                OP_FLOAT: flt = FLT_DS_FP;
                OP_RSV:   flt = FLT_DS_RSV;
                OP_EXT:   flt = FLT_DS_EXT;
                default: begin
                    if (grant) begin
                        pn     = ea[31:PAGE_W];
                        rights = RIGHTS_RW;
                    end else begin
                        flt = FLT_PROT;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/xlat_seq.sv
module xlat_seq
    import xlat_pkg::*;
#(
    parameter int              PAGE_W = 12,
    parameter int              VSID_W = 24,
    parameter logic [8:0]      BUS_ID = 9'h07F,
    localparam int             PN_W   = 32 - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_ea,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_op,
    input  logic              itx_en,
    input  logic              dtx_en,
    input  logic              prob_state,
    output logic              busy,
    output logic              blk_req,
    output logic [31:0]       blk_ea,
    output logic [1:0]        blk_kind,
    output logic              blk_prob,
    input  logic              blk_rsp_valid,
    input  logic              blk_hit,
    input  logic              blk_allow,
    input  logic [PN_W-1:0]   blk_pn,
    input  logic [2:0]        blk_rights,
    output logic [3:0]        seg_idx,
    input  logic [31:0]       seg_word,
    output logic              pt_req,
    output logic [31:0]       pt_ea,
    output logic [VSID_W-1:0] pt_vsid,
    output logic [1:0]        pt_kind,
    output logic              pt_key,
    output logic              pt_nx,
    input  logic              pt_rsp_valid,
    input  logic              pt_found,
    input  logic              pt_allow,
    input  logic [PN_W-1:0]   pt_pn,
    input  logic [2:0]        pt_rights,
    output logic              done,
    output logic              done_ok,
    output logic [PN_W-1:0]   done_pn,
    output logic [2:0]        done_rights,
    output logic [1:0]        exc_class,
    output logic [31:0]       exc_code,
    output logic [31:0]       fault_ea
);

    typedef enum logic [2:0] {
        S_IDLE,
        S_BLOCK,
        S_SEGMENT,
        S_TABLE,
        S_REPORT
    } state_t;

    state_t            state_q, state_d;
    logic [31:0]       ea_q;
    logic [1:0]        kind_q;
    logic [1:0]        op_q;
    logic              prob_q;
    fault_t            res_flt;
    logic [PN_W-1:0]   res_pn;
    logic [2:0]        res_rights;

    logic              accept;
    logic              req_real;
    logic              fetch_q;
    logic              store_q;
    logic              seg_is_ds;
    logic              seg_nx;

    fault_t            ds_flt;
    logic [PN_W-1:0]   ds_pn;
    logic [2:0]        ds_rights;
    logic [1:0]        syn_cls;
    logic [31:0]       syn_code;
    logic [31:0]       syn_faddr;

    assign accept    = (state_q == S_IDLE) && req_valid;
    assign req_real  = (req_kind == ACC_FETCH) ? !itx_en : !dtx_en;
    assign fetch_q   = (kind_q == ACC_FETCH);
    assign store_q   = (kind_q == ACC_WRITE);
    assign seg_is_ds = seg_word[SEG_DSTORE];
    assign seg_nx    = seg_word[SEG_NOEXEC];

    xlat_dstore #(
        .PAGE_W (PAGE_W),
        .BUID_W (9),
        .BUS_ID (BUS_ID)
    ) u_dstore (
        .seg      (seg_word),
        .ea       (ea_q),
        .is_fetch (fetch_q),
        .is_store (store_q),
        .prob     (prob_q),
        .op       (op_q),
        .flt      (ds_flt),
        .pn       (ds_pn),
        .rights   (ds_rights)
    );

    xlat_syndrome u_syndrome (
        .flt      (res_flt),
        .is_fetch (fetch_q),
        .is_store (store_q),
        .ea       (ea_q),
        .cls      (syn_cls),
        .code     (syn_code),
        .faddr    (syn_faddr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid) state_d = req_real ? S_REPORT : S_BLOCK;
            S_BLOCK:   if (blk_rsp_valid) state_d = blk_hit ? S_REPORT : S_SEGMENT;
            S_SEGMENT: begin
                if (seg_is_ds || (fetch_q && seg_nx)) state_d = S_REPORT;
                else                                   state_d = S_TABLE;
            end
            S_TABLE:   if (pt_rsp_valid) state_d = S_REPORT;
            S_REPORT:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request capture and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q       <= '0;
            kind_q     <= ACC_READ;
            op_q       <= OP_INT;
            prob_q     <= 1'b0;
            res_flt    <= FLT_NONE;
            res_pn     <= '0;
            res_rights <= '0;
        end else begin
            if (accept) begin
                ea_q       <= req_ea;
                kind_q     <= req_kind;
                op_q       <= req_op;
                prob_q     <= prob_state;
                res_flt    <= FLT_NONE;
                res_pn     <= req_ea[31:PAGE_W];
                res_rights <= RIGHTS_ALL;
            end
            if (state_q == S_BLOCK && blk_rsp_valid && blk_hit) begin
                res_flt    <= blk_allow ? FLT_NONE : FLT_PROT;
                res_pn     <= blk_allow ? blk_pn : '0;
                res_rights <= blk_allow ? blk_rights : 3'b000;
            end
            if (state_q == S_SEGMENT) begin
                if (seg_is_ds) begin
                    res_flt    <= ds_flt;
                    res_pn     <= ds_pn;
                    res_rights <= ds_rights;
                end else if (fetch_q && seg_nx) begin
                    res_flt    <= FLT_NOEXEC;
                    res_pn     <= '0;
                    res_rights <= 3'b000;
                end
            end
            if (state_q == S_TABLE && pt_rsp_valid) begin
                if (!pt_found)      res_flt <= FLT_MISS;
                else if (!pt_allow) res_flt <= FLT_PROT;
                else                res_flt <= FLT_NONE;
                res_pn     <= (pt_found && pt_allow) ? pt_pn : '0;
                res_rights <= (pt_found && pt_allow) ? pt_rights : 3'b000;
            end
        end
    end

    // outputs
    always_comb begin
        done        = 1'b0;
        done_ok     = 1'b0;
        done_pn     = '0;
        done_rights = '0;
        exc_class   = EXC_NONE;
        exc_code    = '0;
        fault_ea    = '0;
        blk_req     = 1'b0;
        pt_req      = 1'b0;
        unique case (state_q)
            S_BLOCK: blk_req = 1'b1;
            S_TABLE: pt_req  = 1'b1;
            S_REPORT: begin
                done        = 1'b1;
                done_ok     = (res_flt == FLT_NONE);
                done_pn     = res_pn;
                done_rights = res_rights;
                exc_class   = syn_cls;
                exc_code    = syn_code;
                fault_ea    = syn_faddr;
            end
            default: ;
        endcase
    end

    assign busy     = (state_q != S_IDLE);
    assign blk_ea   = ea_q;
    assign blk_kind = kind_q;
    assign blk_prob = prob_q;
    assign seg_idx  = ea_q[31:28];
    assign pt_ea    = ea_q;
    assign pt_kind  = kind_q;
    assign pt_vsid  = seg_word[VSID_W-1:0];
    assign pt_key   = prob_q ? seg_word[SEG_KEY_PR] : seg_word[SEG_KEY_SV];
    assign pt_nx    = seg_nx;

endmodule

// File: rtl/xlat_seq_chk.sv
module xlat_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_ea,
    input logic [1:0]  req_kind,
    input logic        busy,
    input logic        done,
    input logic        done_ok,
    input logic [1:0]  exc_class,
    input logic [31:0] exc_code,
    input logic [31:0] fault_ea,
    input logic        blk_req,
    input logic        blk_rsp_valid,
    input logic        pt_req,
    input logic [1:0]  pt_kind,
    input logic        pt_nx,
    input logic [3:0]  seg_idx
);

    logic [31:0] cap_ea;
    logic [1:0]  cap_kind;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_ea   <= '0;
            cap_kind <= '0;
        end else if (req_valid && !busy) begin
            cap_ea   <= req_ea;
            cap_kind <= req_kind;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!blk_req && !pt_req && !done)); // R12
    AST_ENGINES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_req && pt_req)); // R2
    AST_BLK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_req && !blk_rsp_valid) |=> blk_req); // R2
    AST_SEG_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_req || pt_req) |-> (seg_idx == cap_ea[31:28])); // R4
    AST_NX_NO_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_req && pt_kind == 2'd2) |-> !pt_nx); // R8
    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_ok) |-> (exc_class == 2'd0 && exc_code == 32'h0)); // R9
    AST_STORE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && exc_class == 2'd2 && cap_kind == 2'd1) |-> exc_code[25]); // R10
    AST_DATA_FAULT_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && exc_class[1]) |-> (fault_ea == cap_ea)); // R11
    AST_FETCH_FAULT_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && exc_class == 2'd1) |-> (fault_ea == 32'h0)); // R11

endmodule

bind xlat_seq xlat_seq_chk u_xlat_seq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ea        (req_ea),
    .req_kind      (req_kind),
    .busy          (busy),
    .done          (done),
    .done_ok       (done_ok),
    .exc_class     (exc_class),
    .exc_code      (exc_code),
    .fault_ea      (fault_ea),
    .blk_req       (blk_req),
    .blk_rsp_valid (blk_rsp_valid),
    .pt_req        (pt_req),
    .pt_kind       (pt_kind),
    .pt_nx         (pt_nx),
    .seg_idx       (seg_idx)
);

// File: tb/test_xlat_seq.sv
`timescale 1ns/1ps
module test_xlat_seq;

    localparam int PN_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [31:0]       req_ea = '0;
    logic [1:0]        req_kind = '0;
    logic [1:0]        req_op = '0;
    logic              itx_en = 1'b1;
    logic              dtx_en = 1'b1;
    logic              prob_state = 1'b0;
    logic              busy;
    logic              blk_req;
    logic [31:0]       blk_ea;
    logic [1:0]        blk_kind;
    logic              blk_prob;
    logic              blk_rsp_valid = 1'b0;
    logic              blk_hit = 1'b0;
    logic              blk_allow = 1'b0;
    logic [PN_W-1:0]   blk_pn = '0;
    logic [2:0]        blk_rights = '0;
    logic [3:0]        seg_idx;
    logic [31:0]       seg_word;
    logic              pt_req;
    logic [31:0]       pt_ea;
    logic [23:0]       pt_vsid;
    logic [1:0]        pt_kind;
    logic              pt_key;
    logic              pt_nx;
    logic              pt_rsp_valid = 1'b0;
    logic              pt_found = 1'b0;
    logic              pt_allow = 1'b0;
    logic [PN_W-1:0]   pt_pn = '0;
    logic [2:0]        pt_rights = '0;
    logic              done;
    logic              done_ok;
    logic [PN_W-1:0]   done_pn;
    logic [2:0]        done_rights;
    logic [1:0]        exc_class;
    logic [31:0]       exc_code;
    logic [31:0]       fault_ea;

    logic [31:0] segs [16];
    assign seg_word = segs[seg_idx];

    // engine programming
    bit              cfg_blk_hit, cfg_blk_allow, cfg_pt_found, cfg_pt_allow;
    logic [PN_W-1:0] cfg_blk_pn, cfg_pt_pn;
    logic [2:0]      cfg_blk_rights, cfg_pt_rights;
    int              blk_delay, pt_delay;
    bit              blk_seen, pt_seen;

    // expectations
    bit              exp_active;
    bit              exp_ok, exp_blk, exp_pt, exp_key, exp_nx;
    logic [PN_W-1:0] exp_pn;
    logic [2:0]      exp_rights;
    logic [1:0]      exp_cls;
    logic [31:0]     exp_code, exp_fea;
    string           cur_tag;
    int              done_cnt;
    int              checks = 0;
    int              errors = 0;
    bit              finished = 0;

    xlat_seq i_xlat_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
        .req_kind(req_kind), .req_op(req_op), .itx_en(itx_en), .dtx_en(dtx_en),
        .prob_state(prob_state), .busy(busy), .blk_req(blk_req), .blk_ea(blk_ea),
        .blk_kind(blk_kind), .blk_prob(blk_prob), .blk_rsp_valid(blk_rsp_valid),
        .blk_hit(blk_hit), .blk_allow(blk_allow), .blk_pn(blk_pn),
        .blk_rights(blk_rights), .seg_idx(seg_idx), .seg_word(seg_word),
        .pt_req(pt_req), .pt_ea(pt_ea), .pt_vsid(pt_vsid), .pt_kind(pt_kind),
        .pt_key(pt_key), .pt_nx(pt_nx), .pt_rsp_valid(pt_rsp_valid),
        .pt_found(pt_found), .pt_allow(pt_allow), .pt_pn(pt_pn),
        .pt_rights(pt_rights), .done(done), .done_ok(done_ok), .done_pn(done_pn),
        .done_rights(done_rights), .exc_class(exc_class), .exc_code(exc_code),
        .fault_ea(fault_ea)
    );

    initial forever #5 clk = ~clk;

    task automatic chk(input bit cond, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural reference for one request
    task automatic predict(input logic [31:0] ea, input logic [1:0] kind,
                           input logic [1:0] op, input bit itx, input bit dtx,
                           input bit prob);
        bit fetch, store, key, prot, miss;
        logic [31:0] s;
        fetch = (kind == 2); store = (kind == 1);
        exp_ok = 0; exp_pn = 0; exp_rights = 0; exp_cls = 0; exp_code = 0;
        exp_fea = 0; exp_blk = 0; exp_pt = 0; prot = 0; miss = 0;
        s = segs[ea[31:28]];
        exp_key = prob ? s[29] : s[30];
        exp_nx = s[28];
        if (fetch ? !itx : !dtx) begin
            exp_ok = 1; exp_pn = ea[31:12]; exp_rights = 3'b111;
        end else begin
            exp_blk = 1;
            if (cfg_blk_hit) begin
                if (cfg_blk_allow) begin
                    exp_ok = 1; exp_pn = cfg_blk_pn; exp_rights = cfg_blk_rights;
                end else prot = 1;
            end else if (s[31]) begin
                if (s[28:20] == 9'h07F) begin
                    exp_ok = 1; exp_pn = {s[3:0], ea[27:12]}; exp_rights = 3'b111;
                end else if (fetch) begin
                    exp_cls = 1; exp_code = 32'h1000_0000;
                end else if (op == 1) begin
                    exp_cls = 3; exp_fea = ea;
                end else if (op == 2) begin
                    exp_cls = 2; exp_fea = ea; exp_code = store ? 32'h0600_0000 : 32'h0400_0000;
                end else if (op == 3) begin
                    exp_cls = 2; exp_fea = ea; exp_code = store ? 32'h0610_0000 : 32'h0410_0000;
                end else begin
                    key = exp_key;
                    if ((store && key) || (!store && !key)) begin
                        exp_ok = 1; exp_pn = ea[31:12]; exp_rights = 3'b110;
                    end else prot = 1;
                end
            end else if (fetch && s[28]) begin
                exp_cls = 1; exp_code = 32'h1000_0000;
            end else begin
                exp_pt = 1;
                if (!cfg_pt_found) miss = 1;
                else if (!cfg_pt_allow) prot = 1;
                else begin
                    exp_ok = 1; exp_pn = cfg_pt_pn; exp_rights = cfg_pt_rights;
                end
            end
        end
        if (prot || miss) begin
            if (fetch) begin
                exp_cls = 1; exp_code = miss ? 32'h4000_0000 : 32'h0800_0000;
            end else begin
                exp_cls = 2; exp_fea = ea;
                exp_code = (miss ? 32'h4000_0000 : 32'h0800_0000) + (store ? 32'h0200_0000 : 0);
            end
        end
    endtask

    // engine models
    initial begin
        int bc, pc;
        bc = 0; pc = 0;
        forever begin
            @(negedge clk);
            if (blk_req) begin
                blk_seen = 1;
                blk_rsp_valid = (bc == blk_delay);
                blk_hit = cfg_blk_hit; blk_allow = cfg_blk_allow;
                blk_pn = cfg_blk_pn; blk_rights = cfg_blk_rights;
                bc++;
            end else begin
                blk_rsp_valid = 0; bc = 0;
            end
            if (pt_req) begin
                if (pc == 0) begin
                    chk(pt_key == exp_key, {cur_tag, " R4 pt_key"}, pt_key, exp_key);
                    chk(pt_nx == exp_nx, {cur_tag, " R8 pt_nx"}, pt_nx, exp_nx);
                end
                pt_seen = 1;
                pt_rsp_valid = (pc == pt_delay);
                pt_found = cfg_pt_found; pt_allow = cfg_pt_allow;
                pt_pn = cfg_pt_pn; pt_rights = cfg_pt_rights;
                pc++;
            end else begin
                pt_rsp_valid = 0; pc = 0;
            end
        end
    end

    // per-clock comparison
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                done_cnt++;
                if (!exp_active) chk(0, "R12 unexpected done", 1, 0);
                else begin
                    chk(done_ok == exp_ok, {cur_tag, " ok"}, done_ok, exp_ok);
                    chk(done_pn == exp_pn, {cur_tag, " pn"}, done_pn, exp_pn);
                    chk(done_rights == exp_rights, {cur_tag, " rights"}, done_rights, exp_rights);
                    chk(exc_class == exp_cls, {cur_tag, " class"}, exc_class, exp_cls);
                    chk(exc_code == exp_code, {cur_tag, " code"}, exc_code, exp_code);
                    chk(fault_ea == exp_fea, {cur_tag, " R11 fault_ea"}, fault_ea, exp_fea);
                    chk(blk_seen == exp_blk, {cur_tag, " R2 block used"}, blk_seen, exp_blk);
                    chk(pt_seen == exp_pt, {cur_tag, " R8 table used"}, pt_seen, exp_pt);
                end
            end
        end
    end

    task automatic run(input string tag, input logic [31:0] ea, input logic [1:0] kind,
                       input logic [1:0] op, input bit itx, input bit dtx, input bit prob,
                       input bit poke);
        int n;
        cur_tag = tag;
        predict(ea, kind, op, itx, dtx, prob);
        blk_seen = 0; pt_seen = 0; done_cnt = 0; exp_active = 1;
        @(negedge clk);
        req_valid = 1; req_ea = ea; req_kind = kind; req_op = op;
        itx_en = itx; dtx_en = dtx; prob_state = prob;
        @(negedge clk);
        chk(busy == 1, {tag, " R12 busy"}, busy, 1);
        req_valid = 0;
        if (poke) begin
            req_valid = 1; req_ea = ~ea; req_kind = 2'd2; prob_state = !prob;
            @(negedge clk);
            req_valid = 0;
        end
        n = 0;
        while (done_cnt == 0 && n < 200) begin
            @(negedge clk); n++;
        end
        repeat (4) @(negedge clk);
        exp_active = 0;
        chk(done_cnt == 1, {tag, " R12 done count"}, done_cnt, 1);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) segs[i] = 32'h0000_0000 | (i << 4);
        segs[1] = 32'h1000_0ABC;                  // no-execute page segment
        segs[2] = 32'h87F0_0005;                  // forced direct store
        segs[3] = 32'h8010_0000;                  // direct store, keys 0
        segs[4] = 32'hE010_0000;                  // direct store, both keys 1
        segs[5] = 32'h2000_1234;                  // user key set
        segs[6] = 32'hC010_0000;                  // direct store, supervisor key only
        cfg_blk_hit = 0; cfg_blk_allow = 0; cfg_blk_pn = '0; cfg_blk_rights = 0;
        cfg_pt_found = 0; cfg_pt_allow = 0; cfg_pt_pn = '0; cfg_pt_rights = 0;
        blk_delay = 0; pt_delay = 0; exp_active = 0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0, "R12 reset outputs", {busy, done}, 0);
        chk(blk_req == 0 && pt_req == 0, "R12 reset engines", {blk_req, pt_req}, 0);
        rst_n = 1;
        @(negedge clk);

        run("R1 real fetch", 32'h7654_3210, 2, 0, 0, 1, 0, 0);
        run("R1 real write", 32'h0123_4567, 1, 0, 1, 0, 0, 0);
        run("R1 kind3 real", 32'hABCD_E000, 3, 0, 1, 0, 1, 0);

        cfg_blk_hit = 1; cfg_blk_allow = 1; cfg_blk_pn = 20'hBEEF1; cfg_blk_rights = 3'b101;
        blk_delay = 2;
        run("R2 block hit", 32'h0000_5000, 0, 0, 1, 1, 0, 0);
        cfg_blk_allow = 0;
        run("R3 block prot write", 32'h0010_2000, 1, 0, 1, 1, 0, 0);
        run("R3 block prot fetch", 32'h0010_2000, 2, 0, 1, 1, 0, 0);

        cfg_blk_hit = 0; blk_delay = 1;
        cfg_pt_found = 1; cfg_pt_allow = 1; cfg_pt_pn = 20'h13579; cfg_pt_rights = 3'b011;
        pt_delay = 3;
        run("R9 table ok", 32'h0345_6000, 0, 0, 1, 1, 0, 1);
        run("R4 user key", 32'h5000_1000, 1, 0, 1, 1, 1, 0);
        run("R4 sup key", 32'h5000_1000, 0, 0, 1, 1, 0, 0);
        cfg_pt_found = 0;
        run("R9 miss read", 32'h0900_0000, 0, 0, 1, 1, 0, 0);
        run("R10 miss write", 32'h0900_0004, 1, 0, 1, 1, 0, 0);
        run("R9 miss fetch", 32'h0900_0008, 2, 0, 1, 1, 0, 0);
        cfg_pt_found = 1; cfg_pt_allow = 0;
        run("R9 prot fetch", 32'h0A00_0000, 2, 0, 1, 1, 0, 0);
        run("R10 prot write", 32'h0A00_0010, 1, 0, 1, 1, 0, 0);

        cfg_pt_allow = 1;
        run("R8 nx fetch", 32'h1234_5678, 2, 0, 1, 1, 0, 0);
        run("R8 nx data", 32'h1234_5678, 0, 0, 1, 1, 0, 0);

        run("R5 forced ds fetch", 32'h2ABC_DEF0, 2, 0, 1, 1, 0, 0);
        run("R5 forced ds write", 32'h2123_4567, 1, 3, 1, 1, 1, 0);
        run("R6 ds fetch", 32'h3000_1000, 2, 0, 1, 1, 0, 0);
        run("R6 ds float", 32'h3000_2000, 0, 1, 1, 1, 0, 0);
        run("R6 ds rsv read", 32'h3000_3000, 0, 2, 1, 1, 0, 0);
        run("R10 ds rsv write", 32'h3000_3004, 1, 2, 1, 1, 0, 0);
        run("R6 ds ext read", 32'h3000_4000, 0, 3, 1, 1, 0, 0);
        run("R10 ds ext write", 32'h3000_4004, 1, 3, 1, 1, 0, 0);
        run("R7 ds int read key0", 32'h3000_5000, 0, 0, 1, 1, 0, 0);
        run("R7 ds int write key0", 32'h3000_5004, 1, 0, 1, 1, 0, 0);
        run("R7 ds int read key1", 32'h4000_6000, 0, 0, 1, 1, 1, 0);
        run("R7 ds int write key1", 32'h4000_6004, 1, 0, 1, 1, 0, 0);
        run("R7 ds user key0", 32'h6000_7000, 0, 0, 1, 1, 1, 0);
        run("R7 ds sup key1", 32'h6000_7000, 0, 0, 1, 1, 0, 0);
        run("R12 busy poke", 32'h0777_0000, 1, 0, 1, 1, 0, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule